// File: doc/BRIEF.md
# Paged Data-Memory Command Interpreter

This block is a small nonvolatile-style data store that a processor reaches through a byte-wide register bus. The store holds 160 pages of four bytes each, 640 bytes in total. The host writes a page number and up to four data bytes into holding registers. It then writes a command code into a command register. The command either copies the selected page into the data registers, programs the data registers into the page, checks the page against the data registers, erases one page, or erases the whole store.

Programming follows flash rules. Erasing sets bytes to FFh, and programming can only clear bits. The stored word becomes the bitwise AND of the old contents and the data registers, so a page must be erased before it is programmed. Each command holds a busy flag high for a fixed number of cycles. While busy is high, every write on the bus is dropped. Reading the command register returns the result of the last verify, an error code, or the last command code accepted.

Top module: `pmem_cmd_top`

## Requirements
- R1: After synchronous reset, registers 0 to 5 read 00h, busy is low, and every page of the store holds FFh in all four bytes.
- R2: Register offsets are fixed. Offset 0 is the page number. Offsets 1 to 4 are data bytes 1 to 4, where byte 1 is page byte 0. Offset 5 is the command register. Offsets 0 to 4 read back the last value written or loaded.
- R3: Command 01h with a page number of 9Fh or below copies page byte k of that page into data byte k+1.
- R4: Command 02h with a page number of 9Fh or below replaces the page with the bitwise AND of its old contents and the four data bytes.
- R5: Command 04h with a page number of 9Fh or below makes the command register read 00h if the page equals the data bytes, and 01h otherwise. The store and the data bytes do not change.
- R6: Command 05h with a page number of 9Fh or below sets all four bytes of that page to FFh. No other page changes.
- R7: Command 06h sets every page to FFh, whatever the page number is.
- R8: Codes 00h, 03h and 07h to FFh are rejected. Codes 01h, 02h, 04h and 05h are rejected when the page number is above 9Fh. A rejected command changes neither the store nor the data bytes, and the command register then reads FEh.
- R9: Busy goes high on the cycle after a command is accepted. It stays high for 2 cycles after read, verify and rejected commands, 6 cycles after program and page erase, and 12 cycles after erase-all.
- R10: Any register write made while busy is high is ignored.
- R11: After an accepted command that is neither a verify nor rejected, the command register reads back the code that was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; rd_data is 00h when low |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| busy | output | 1 | Command in progress; writes are ignored |

## Verification
The bench reprograms a page that already holds data. A design that overwrote the page instead of ANDing into it would leave the second pattern unchanged. It verifies both a matching and a mismatching page; a design that swapped the sense of the result, or that let verify touch the data bytes, shows up there. Page erase is checked against a neighbouring programmed page, which a loose index compare would wipe. Reserved codes and page number A0h are checked to confirm they leave the data bytes and the store alone and report FEh. Busy lengths are counted per command class. A page write made during busy must not take effect, which catches a design that forgets to gate the bus.

// File: rtl/pmem_pkg.sv
// Package: shared constants for the paged data-memory command block.
// Assumes a byte-wide register bus with a 3-bit offset.
package pmem_pkg;
    localparam int BYTES_PER_PAGE = 4;
    localparam int PAGE_WORD_W    = 8 * BYTES_PER_PAGE;

    // register offsets on the host bus
    localparam logic [2:0] OFS_PAGE = 3'd0;
    localparam logic [2:0] OFS_CMD  = 3'd5;

    // command codes
    localparam logic [7:0] CMD_READ      = 8'h01;
    localparam logic [7:0] CMD_PROG      = 8'h02;
    localparam logic [7:0] CMD_VERIFY    = 8'h04;
    localparam logic [7:0] CMD_ERASE     = 8'h05;
    localparam logic [7:0] CMD_ERASE_ALL = 8'h06;

    // command register readback values
    localparam logic [7:0] STAT_MATCH    = 8'h00;
    localparam logic [7:0] STAT_MISMATCH = 8'h01;
    localparam logic [7:0] STAT_ERROR    = 8'hFE;

    typedef enum logic [1:0] {
        AOP_NONE,
        AOP_PROG,
        AOP_ERASE,
        AOP_ERASE_ALL
    } arr_op_e;
endpackage

// File: rtl/pmem_regfile.sv
// Module: pmem_regfile
// Holds the page-number register and the data-byte registers.
// Assumes host writes are already gated by busy. A load from the store
// takes priority over a host write in the same cycle; the sequencer
// never asks for both at once.
module pmem_regfile
    import pmem_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int NBYTES = BYTES_PER_PAGE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_we,
    input  logic [2:0]            host_sel,
    input  logic [7:0]            host_wdata,
    input  logic                  load_en,
    input  logic [8*NBYTES-1:0]   load_word,
    output logic [PAGE_W-1:0]     page_q,
    output logic [8*NBYTES-1:0]   data_q
);
    // page number register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (host_we && host_sel == OFS_PAGE) begin
            page_q <= host_wdata[PAGE_W-1:0];
        end
    end

    // one data byte register per page byte (byte k sits at offset k+1)
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam logic [2:0] SEL = 3'(b + 1);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[8*b +: 8] <= 8'h00;
            end else if (load_en) begin
                data_q[8*b +: 8] <= load_word[8*b +: 8];
            end else if (host_we && host_sel == SEL) begin
                data_q[8*b +: 8] <= host_wdata;
            end
        end
    end
endmodule

// File: rtl/pmem_array.sv
// Module: pmem_array
// The page store. Erase sets a page to all ones. Program ANDs the new
// word into the old one. Reset leaves the store fully erased.
// Assumes idx is checked against PAGES by the sequencer before a write;
// an out-of-range read returns all ones.
module pmem_array
    import pmem_pkg::*;
#(
    parameter int PAGES  = 160,
    parameter int WORD_W = PAGE_WORD_W,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  arr_op_e           op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rword
);
    logic [WORD_W-1:0] mem [PAGES];

    // apply the erase and program operations to each page
    always_ff @(posedge clk) begin
        for (int p = 0; p < PAGES; p++) begin
            if (!rst_n || op == AOP_ERASE_ALL ||
                (op == AOP_ERASE && idx == IDX_W'(p))) begin
                mem[p] <= '1;
            end else if (op == AOP_PROG && idx == IDX_W'(p)) begin
                mem[p] <= mem[p] & wword;
            end
        end
    end

    // combinational read of the selected page
    always_comb begin
        rword = '1;
        for (int p = 0; p < PAGES; p++) begin
            if (idx == IDX_W'(p)) rword = mem[p];
        end
    end
endmodule

// File: rtl/pmem_sequencer.sv
// Module: pmem_sequencer
// Decodes an accepted command and drives the store and the data
// registers in that same cycle. It then runs the busy window and keeps
// the value that the command register reads back.
// Assumes cmd_we is only high when busy is low.
module pmem_sequencer
    import pmem_pkg::*;
#(
    parameter int PAGES     = 160,
    parameter int IDX_W     = 8,
    parameter int WORD_W    = PAGE_WORD_W,
    parameter int LAT_SHORT = 2,
    parameter int LAT_LONG  = 6,
    parameter int LAT_ALL   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_code,
    input  logic [IDX_W-1:0]  page,
    input  logic [WORD_W-1:0] page_word,
    input  logic [WORD_W-1:0] data_word,
    output arr_op_e           arr_op,
    output logic              load_en,
    output logic [7:0]        status_q,
    output logic              busy
);
    localparam int LAT_MAX = (LAT_ALL > LAT_LONG) ?
                             ((LAT_ALL > LAT_SHORT) ? LAT_ALL : LAT_SHORT) :
                             ((LAT_LONG > LAT_SHORT) ? LAT_LONG : LAT_SHORT);
    localparam int CNT_W = $clog2(LAT_MAX + 1);

    logic             page_ok;
    logic [7:0]       status_d;
    logic [CNT_W-1:0] lat_d;
    logic [CNT_W-1:0] cnt_q;

    assign page_ok = (page < IDX_W'(PAGES));

    // decode the command into a store operation, readback value and latency
    always_comb begin
        arr_op   = AOP_NONE;
        load_en  = 1'b0;
        status_d = cmd_code;
        lat_d    = CNT_W'(LAT_SHORT);
        unique case (cmd_code)
            CMD_READ: begin
                if (page_ok) load_en = cmd_we;
                else         status_d = STAT_ERROR;
            end
            CMD_PROG: begin
                if (page_ok) begin
                    arr_op = cmd_we ? AOP_PROG : AOP_NONE;
                    lat_d  = CNT_W'(LAT_LONG);
                end else begin
                    status_d = STAT_ERROR;
                end
            end
            CMD_VERIFY: begin
                if (!page_ok)                    status_d = STAT_ERROR;
                else if (page_word == data_word) status_d = STAT_MATCH;
                else                             status_d = STAT_MISMATCH;
            end
            CMD_ERASE: begin
                if (page_ok) begin
                    arr_op = cmd_we ? AOP_ERASE : AOP_NONE;
                    lat_d  = CNT_W'(LAT_LONG);
                end else begin
                    status_d = STAT_ERROR;
                end
            end
            CMD_ERASE_ALL: begin
                arr_op = cmd_we ? AOP_ERASE_ALL : AOP_NONE;
                lat_d  = CNT_W'(LAT_ALL);
            end
            default: status_d = STAT_ERROR;
        endcase
    end

    // command register readback value
    always_ff @(posedge clk) begin
        if (!rst_n)      status_q <= 8'h00;
        else if (cmd_we) status_q <= status_d;
    end

    // busy window counter
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cmd_we)         cnt_q <= lat_d;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/pmem_cmd_top.sv
// Module: pmem_cmd_top
// Register-bus front end of the paged data memory. It gates host writes
// with busy, sends writes at offset 5 to the command sequencer and the
// rest to the register file, and muxes the read data.
// Assumes at most one of reg_wr and reg_rd matters per cycle; a read has
// no side effects.
module pmem_cmd_top
    import pmem_pkg::*;
#(
    parameter int PAGES     = 160,
    parameter int LAT_SHORT = 2,
    parameter int LAT_LONG  = 6,
    parameter int LAT_ALL   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       busy
);
    localparam int IDX_W  = 8;
    localparam int WORD_W = PAGE_WORD_W;

    logic              accept;
    logic              cmd_we;
    logic              reg_we;
    logic              load_en;
    arr_op_e           arr_op;
    logic [IDX_W-1:0]  page_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] page_word;
    logic [7:0]        status_q;

    // split accepted writes between the command register and the holding registers
    assign accept = reg_wr && !busy;
    assign cmd_we = accept && (reg_addr == OFS_CMD);
    assign reg_we = accept && (reg_addr != OFS_CMD);

    pmem_regfile #(
        .PAGE_W (IDX_W),
        .NBYTES (BYTES_PER_PAGE)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (reg_we),
        .host_sel   (reg_addr),
        .host_wdata (wr_data),
        .load_en    (load_en),
        .load_word  (page_word),
        .page_q     (page_q),
        .data_q     (data_q)
    );

    pmem_array #(
        .PAGES  (PAGES),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (arr_op),
        .idx   (page_q),
        .wword (data_q),
        .rword (page_word)
    );

    pmem_sequencer #(
        .PAGES     (PAGES),
        .IDX_W     (IDX_W),
        .WORD_W    (WORD_W),
        .LAT_SHORT (LAT_SHORT),
        .LAT_LONG  (LAT_LONG),
        .LAT_ALL   (LAT_ALL)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_code  (wr_data),
        .page      (page_q),
        .page_word (page_word),
        .data_word (data_q),
        .arr_op    (arr_op),
        .load_en   (load_en),
        .status_q  (status_q),
        .busy      (busy)
    );

    // read data mux
    always_comb begin
        rd_data = 8'h00;
        if (reg_rd) begin
            case (reg_addr)
                3'd0:    rd_data = page_q;
                3'd1:    rd_data = data_q[7:0];
                3'd2:    rd_data = data_q[15:8];
                3'd3:    rd_data = data_q[23:16];
                3'd4:    rd_data = data_q[31:24];
                3'd5:    rd_data = status_q;
                default: rd_data = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/pmem_checker.sv
// Module: pmem_checker
// Temporal checks on the command block. It is attached to every
// pmem_cmd_top through the bind statement at the end of this file.
module pmem_checker #(
    parameter int PAGES = 160
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  reg_addr,
    input logic        reg_wr,
    input logic [7:0]  wr_data,
    input logic        busy,
    input logic [7:0]  page_q,
    input logic [31:0] data_q,
    input logic [31:0] page_word,
    input logic [7:0]  status_q
);
    logic cmd_acc;
    assign cmd_acc = reg_wr && !busy && (reg_addr == 3'd5);

    AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_acc |=> busy);  // R9

    AST_PAGE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 3'd0) |=> $stable(page_q));  // R10

    AST_READ_LOADS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && wr_data == 8'h01 && page_q < 8'(PAGES)) |=> (data_q == $past(page_word)));  // R3

    AST_VERIFY_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && wr_data == 8'h04) |=> $stable(data_q));  // R5

    AST_BAD_PAGE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && wr_data == 8'h02 && page_q >= 8'(PAGES)) |=> (status_q == 8'hFE));  // R8
endmodule

bind pmem_cmd_top pmem_checker #(.PAGES(PAGES)) i_pmem_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wr_data   (wr_data),
    .busy      (busy),
    .page_q    (page_q),
    .data_q    (data_q),
    .page_word (page_word),
    .status_q  (status_q)
);

// File: tb/test_pmem_cmd_top.sv
// Directed bench for pmem_cmd_top. Each task drives one scenario and
// checks its own results. Inputs change on the falling edge, and outputs
// are sampled shortly after it.
module test_pmem_cmd_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [160];

    always #2 clk = ~clk;

    pmem_cmd_top i_pmem_cmd_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .busy     (busy)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = rd_data;
        reg_rd = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_cmd(input logic [7:0] code, output int lat);
        bus_write(3'd5, code);
        count_busy(lat);
    endtask

    task automatic set_page(input logic [7:0] p);
        bus_write(3'd0, p);
    endtask

    task automatic set_data(input logic [31:0] w);
        for (int b = 0; b < 4; b++) bus_write(3'(b + 1), w[8*b +: 8]);
    endtask

    task automatic get_data(output logic [31:0] w);
        logic [7:0] v;
        for (int b = 0; b < 4; b++) begin
            bus_read(3'(b + 1), v);
            w[8*b +: 8] = v;
        end
    endtask

    task automatic get_status(output logic [7:0] s);
        bus_read(3'd5, s);
    endtask

    task automatic read_page(input logic [7:0] p, output logic [31:0] w);
        int lat;
        set_page(p);
        do_cmd(8'h01, lat);
        get_data(w);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 32'd0);
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), v);
            check("R1 register reset value", 32'(v), 32'h00);
        end
    endtask

    task automatic t_regs();
        logic [7:0] v;
        logic [31:0] w;
        set_page(8'h12);
        bus_read(3'd0, v);
        check("R2 page register readback", 32'(v), 32'h12);
        set_data(32'h44332211);
        get_data(w);
        check("R2 data byte readback", w, 32'h44332211);
    endtask

    task automatic t_erased_read();
        logic [31:0] w;
        int lat;
        set_page(8'h03);
        do_cmd(8'h01, lat);
        check("R9 read busy length", 32'(lat), 32'd2);
        get_data(w);
        check("R1 R3 erased page after reset", w, 32'hFFFFFFFF);
        read_page(8'h9F, w);
        check("R3 last page reads erased", w, 32'hFFFFFFFF);
    endtask

    task automatic t_program();
        logic [31:0] w;
        logic [7:0] s;
        int lat;
        set_page(8'h05);
        set_data(32'h44332211);
        do_cmd(8'h02, lat);
        check("R9 program busy length", 32'(lat), 32'd6);
        get_status(s);
        check("R11 readback after program", 32'(s), 32'h02);
        model[5] = model[5] & 32'h44332211;
        set_data(32'h0);
        read_page(8'h05, w);
        check("R3 R4 read back programmed page", w, model[5]);
        set_page(8'h06);
        set_data(32'h0FF00FF0);
        do_cmd(8'h02, lat);
        model[6] = model[6] & 32'h0FF00FF0;
        set_page(8'h05);
        set_data(32'h55AA0FF0);
        do_cmd(8'h02, lat);
        model[5] = model[5] & 32'h55AA0FF0;
        read_page(8'h05, w);
        check("R4 reprogram ANDs into page", w, model[5]);
    endtask

    task automatic t_verify();
        logic [31:0] w;
        logic [7:0] s;
        int lat;
        set_page(8'h05);
        set_data(model[5]);
        do_cmd(8'h04, lat);
        check("R9 verify busy length", 32'(lat), 32'd2);
        get_status(s);
        check("R5 verify match", 32'(s), 32'h00);
        set_data(model[5] ^ 32'h00000100);
        do_cmd(8'h04, lat);
        get_status(s);
        check("R5 verify mismatch", 32'(s), 32'h01);
        get_data(w);
        check("R5 verify keeps data", w, model[5] ^ 32'h00000100);
        read_page(8'h05, w);
        check("R5 verify keeps page", w, model[5]);
    endtask

    task automatic t_erase_page();
        logic [31:0] w;
        logic [7:0] s;
        int lat;
        set_page(8'h05);
        do_cmd(8'h05, lat);
        check("R9 erase busy length", 32'(lat), 32'd6);
        get_status(s);
        check("R11 readback after erase", 32'(s), 32'h05);
        model[5] = 32'hFFFFFFFF;
        read_page(8'h05, w);
        check("R6 erased page", w, 32'hFFFFFFFF);
        read_page(8'h06, w);
        check("R6 neighbour page kept", w, model[6]);
    endtask

    task automatic t_reserved();
        logic [31:0] w;
        logic [7:0] s;
        logic [7:0] codes [4] = '{8'h03, 8'h07, 8'hFF, 8'h00};
        int lat;
        set_page(8'h06);
        set_data(32'hA5A5A5A5);
        foreach (codes[i]) begin
            do_cmd(codes[i], lat);
            check("R9 rejected busy length", 32'(lat), 32'd2);
            get_status(s);
            check("R8 reserved code readback", 32'(s), 32'hFE);
            get_data(w);
            check("R8 reserved keeps data", w, 32'hA5A5A5A5);
        end
        set_page(8'hA0);
        do_cmd(8'h01, lat);
        get_status(s);
        check("R8 read of page A0 rejected", 32'(s), 32'hFE);
        get_data(w);
        check("R8 bad page keeps data", w, 32'hA5A5A5A5);
        do_cmd(8'h05, lat);
        check("R9 rejected erase busy length", 32'(lat), 32'd2);
        get_status(s);
        check("R8 erase of page A0 rejected", 32'(s), 32'hFE);
        do_cmd(8'h02, lat);
        read_page(8'h06, w);
        check("R8 store unchanged after rejects", w, model[6]);
        read_page(8'h9F, w);
        check("R8 last page unchanged", w, model[159]);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        logic [31:0] w;
        int lat;
        set_page(8'h07);
        set_data(32'h00000000);
        bus_write(3'd5, 8'h02);
        model[7] = 32'h0;
        bus_write(3'd0, 8'h33);
        bus_write(3'd1, 8'h77);
        count_busy(lat);
        bus_read(3'd0, v);
        check("R10 page write during busy ignored", 32'(v), 32'h07);
        bus_read(3'd1, v);
        check("R10 data write during busy ignored", 32'(v), 32'h00);
        set_data(32'hFFFFFFFF);
        read_page(8'h07, w);
        check("R10 program during busy completed", w, 32'h0);
    endtask

    task automatic t_erase_all();
        logic [31:0] w;
        int lat;
        set_page(8'hC8);
        do_cmd(8'h06, lat);
        check("R9 erase-all busy length", 32'(lat), 32'd12);
        read_page(8'h06, w);
        check("R7 page 06 erased", w, 32'hFFFFFFFF);
        read_page(8'h07, w);
        check("R7 page 07 erased", w, 32'hFFFFFFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        for (int p = 0; p < 160; p++) model[p] = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_erased_read();
        t_program();
        t_verify();
        t_erase_page();
        t_reserved();
        t_busy_ignore();
        t_erase_all();
        report();
    end
endmodule